// File: doc/BRIEF.md
# Predicated Vector Multiply-Add Unit

This block decodes one 32-bit word from the predicated integer multiply-add group and carries out the operation across a fixed-width vector. The decoder reports whether the word is in the group. It also produces the register numbers the surrounding pipeline needs: the destination, the two multiplier operands, the addend and the governing predicate.

The pipeline reads the register values named by those indices and presents them on the vector inputs, together with the old destination value and a predicate bitmap that has one bit per vector byte. The unit then computes the new destination lane by lane. An active lane receives `addend + n*m` or `addend - n*m`, wrapped to the lane width. An inactive lane keeps its old contents. Lanes are 8, 16, 32 or 64 bits wide.

The opcode decides whether the destination register doubles as the addend or as the multiplicand `n`. An optional output register, enabled by a parameter, lets the unit sit on a pipeline stage boundary.

Top module: `pvma_unit`

## Requirements
- R1: `match_o` is 1 exactly when word bits 31:24 equal 8'h04, bit 21 is 0 and bits 15:13 are one of 3'b010, 3'b011, 3'b110 or 3'b111. For every other word it is 0.
- R2: Word bits 23:22 select the lane width: code 0 selects 8 bits, code 1 selects 16, code 2 selects 32 and code 3 selects 64. Lane k occupies vector bits [k*LW +: LW].
- R3: Word bit 13 = 0 selects multiply-add. An active lane becomes `a + n*m` modulo 2^LW.
- R4: Word bit 13 = 1 selects multiply-subtract. An active lane becomes `a - n*m` modulo 2^LW.
- R5: A lane is active exactly when predicate bit `k*(LW/8)` is 1, which is the bit for the lane's lowest byte. The other predicate bits of that lane have no effect.
- R6: An inactive lane of `result_o` equals the same lane of `vec_d_i`.
- R7: For bits 15:13 = 3'b010 or 3'b011, the index outputs are as follows: `rd_o` = bits 4:0, `ra_o` = `rd_o`, `rn_o` = bits 9:5, `rm_o` = bits 20:16 and `pg_o` = bits 12:10.
- R8: For bits 15:13 = 3'b110 or 3'b111, `rn_o` = `rd_o` = bits 4:0, `ra_o` = bits 9:5, `rm_o` = bits 20:16 and `pg_o` = bits 12:10.
- R9: For a word that does not match, `result_o` equals `vec_d_i` and every index output is 0.
- R10: With `OUT_REG`=1, the outputs show the inputs sampled at the previous rising clock edge, and a synchronous reset clears all outputs to 0. With `OUT_REG`=0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| vec_n_i | input | VEC_W | Value of the first multiplier operand register |
| vec_m_i | input | VEC_W | Value of the second multiplier operand register |
| vec_a_i | input | VEC_W | Value of the addend register |
| vec_d_i | input | VEC_W | Old destination value |
| pred_i | input | VEC_W/8 | Governing predicate, one bit per byte |
| match_o | output | 1 | Word belongs to the multiply-add group |
| rd_o | output | 5 | Destination register index |
| rn_o | output | 5 | First multiplier register index |
| rm_o | output | 5 | Second multiplier register index |
| ra_o | output | 5 | Addend register index |
| pg_o | output | 3 | Governing predicate index |
| result_o | output | VEC_W | New destination value |

## Verification
The bench builds two copies of the unit and drives both with the same stimulus. The first uses the defaults, a 256-bit vector with the output register present, which reaches 32 byte lanes and the one-cycle latency and reset paths. The second is a 128-bit combinational build: it checks that narrowing the vector drops the upper lanes and predicate bits cleanly, and that the same results appear with no clock stage. Together they cover all four lane sizes and both operand forms at each width.

// File: rtl/pvma_pkg.sv
package pvma_pkg;

  typedef enum logic [1:0] {
    LANE_B = 2'd0,
    LANE_H = 2'd1,
    LANE_W = 2'd2,
    LANE_D = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic       hit;
    logic       subtract;
    logic       dst_is_mcand;
    lane_sz_e   sz;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [4:0] ra;
    logic [2:0] pg;
  } pvma_dec_t;

  localparam logic [7:0] GROUP_TAG = 8'h04;

endpackage

// File: rtl/pvma_decode.sv
module pvma_decode
  import pvma_pkg::*;
(
  input  logic [31:0] insn,
  output pvma_dec_t   dec
);

  logic in_group;

  // bit 14 set covers opcodes 010, 011, 110 and 111 exactly
  assign in_group = (insn[31:24] == GROUP_TAG) && !insn[21] && insn[14];

  always_comb begin
    dec = '0;
    if (in_group) begin
      dec.hit          = 1'b1;
      dec.subtract     = insn[13];
      dec.dst_is_mcand = insn[15];
      dec.sz           = lane_sz_e'(insn[23:22]);
      dec.rd           = insn[4:0];
      dec.rm           = insn[20:16];
      dec.pg           = insn[12:10];
      if (insn[15]) begin
        dec.rn = insn[4:0];
        dec.ra = insn[9:5];
      end else begin
        dec.rn = insn[9:5];
        dec.ra = insn[4:0];
      end
    end
  end

endmodule

// File: rtl/pvma_lane.sv
module pvma_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] n,
  input  logic [LW-1:0] m,
  input  logic          sub,
  output logic [LW-1:0] r
);

  logic [LW-1:0] prod;

  // low LW bits of the product suffice: the result wraps to the lane
  assign prod = n * m;
  assign r    = sub ? (a - prod) : (a + prod);

endmodule

// File: rtl/pvma_datapath.sv
module pvma_datapath
  import pvma_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [VEC_W-1:0]   vn,
  input  logic [VEC_W-1:0]   vm,
  input  logic [VEC_W-1:0]   va,
  input  logic [VEC_W-1:0]   vd,
  input  logic [VEC_W/8-1:0] pred,
  input  logic               en,
  input  logic               sub,
  input  lane_sz_e           sz,
  output logic [VEC_W-1:0]   res
);

  localparam int NSZ = 4;

  logic [NSZ-1:0][VEC_W-1:0] cand;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int LB = LW / 8;
    localparam int NL = VEC_W / LW;
    for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [LW-1:0] lane_r;
      pvma_lane #(.LW(LW)) u_lane (
        .a  (va[k*LW +: LW]),
        .n  (vn[k*LW +: LW]),
        .m  (vm[k*LW +: LW]),
        .sub(sub),
        .r  (lane_r)
      );
      // only the predicate bit of the lane's lowest byte governs it
      assign cand[s][k*LW +: LW] = pred[k*LB] ? lane_r : vd[k*LW +: LW];
    end
  end

  always_comb begin
    res = vd;
    if (en) res = cand[sz];
  end

endmodule

// File: rtl/pvma_unit.sv
module pvma_unit
  import pvma_pkg::*;
#(
  parameter int VEC_W   = 256,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        insn_i,
  input  logic [VEC_W-1:0]   vec_n_i,
  input  logic [VEC_W-1:0]   vec_m_i,
  input  logic [VEC_W-1:0]   vec_a_i,
  input  logic [VEC_W-1:0]   vec_d_i,
  input  logic [VEC_W/8-1:0] pred_i,
  output logic               match_o,
  output logic [4:0]         rd_o,
  output logic [4:0]         rn_o,
  output logic [4:0]         rm_o,
  output logic [4:0]         ra_o,
  output logic [2:0]         pg_o,
  output logic [VEC_W-1:0]   result_o
);

  pvma_dec_t        dec;
  logic [VEC_W-1:0] res_c;

  pvma_decode u_decode (
    .insn(insn_i),
    .dec (dec)
  );

  pvma_datapath #(.VEC_W(VEC_W)) u_datapath (
    .vn  (vec_n_i),
    .vm  (vec_m_i),
    .va  (vec_a_i),
    .vd  (vec_d_i),
    .pred(pred_i),
    .en  (dec.hit),
    .sub (dec.subtract),
    .sz  (dec.sz),
    .res (res_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        match_o  <= 1'b0;
        rd_o     <= '0;
        rn_o     <= '0;
        rm_o     <= '0;
        ra_o     <= '0;
        pg_o     <= '0;
        result_o <= '0;
      end else begin
        match_o  <= dec.hit;
        rd_o     <= dec.rd;
        rn_o     <= dec.rn;
        rm_o     <= dec.rm;
        ra_o     <= dec.ra;
        pg_o     <= dec.pg;
        result_o <= res_c;
      end
    end

    assert_reg_latency_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (match_o == $past(dec.hit)) && (result_o == $past(res_c)));
  end else begin : g_comb
    assign match_o  = dec.hit;
    assign rd_o     = dec.rd;
    assign rn_o     = dec.rn;
    assign rm_o     = dec.rm;
    assign ra_o     = dec.ra;
    assign pg_o     = dec.pg;
    assign result_o = res_c;
  end

  assert_group_shape_R1: assert property (@(posedge clk) disable iff (rst)
    dec.hit |-> (insn_i[31:24] == 8'h04) && !insn_i[21] && insn_i[14]);

  assert_nomatch_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !dec.hit |-> (res_c == vec_d_i));

  assert_lane0_inactive_R6: assert property (@(posedge clk) disable iff (rst)
    !pred_i[0] |-> (res_c[7:0] == vec_d_i[7:0]));

  assert_addend_form_R7: assert property (@(posedge clk) disable iff (rst)
    (dec.hit && !insn_i[15]) |-> (dec.ra == insn_i[4:0]) && (dec.rn == insn_i[9:5]));

  assert_mcand_form_R8: assert property (@(posedge clk) disable iff (rst)
    (dec.hit && insn_i[15]) |-> (dec.rn == insn_i[4:0]) && (dec.ra == insn_i[9:5]));

endmodule

// File: tb/pvma_unit_bench.sv
module pvma_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  insn = '0;
  logic [255:0] vn = '0, vm = '0, va = '0, vd = '0;
  logic [31:0]  pred = '0;

  logic         w_match;
  logic [4:0]   w_rd, w_rn, w_rm, w_ra;
  logic [2:0]   w_pg;
  logic [255:0] w_res;

  logic         s_match;
  logic [4:0]   s_rd, s_rn, s_rm, s_ra;
  logic [2:0]   s_pg;
  logic [127:0] s_res;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pvma_unit u_pvma_unit (
    .clk(clk), .rst(rst), .insn_i(insn),
    .vec_n_i(vn), .vec_m_i(vm), .vec_a_i(va), .vec_d_i(vd), .pred_i(pred),
    .match_o(w_match), .rd_o(w_rd), .rn_o(w_rn), .rm_o(w_rm), .ra_o(w_ra),
    .pg_o(w_pg), .result_o(w_res)
  );

  pvma_unit #(.VEC_W(128), .OUT_REG(1'b0)) u_pvma_unit_narrow (
    .clk(clk), .rst(rst), .insn_i(insn),
    .vec_n_i(vn[127:0]), .vec_m_i(vm[127:0]), .vec_a_i(va[127:0]),
    .vec_d_i(vd[127:0]), .pred_i(pred[15:0]),
    .match_o(s_match), .rd_o(s_rd), .rn_o(s_rn), .rm_o(s_rm), .ra_o(s_ra),
    .pg_o(s_pg), .result_o(s_res)
  );

  function automatic logic [31:0] mk(input logic [1:0] esz, input logic [2:0] op,
                                     input logic [4:0] rm, input logic [2:0] pg,
                                     input logic [4:0] rs, input logic [4:0] rd);
    return {8'h04, esz, 1'b0, rm, op, pg, rs, rd};
  endfunction

  function automatic logic [255:0] model(input logic [31:0] w, input logic [255:0] n,
      input logic [255:0] m, input logic [255:0] a, input logic [255:0] d,
      input logic [31:0] p, input int nbytes);
    logic [255:0] r, mask;
    logic [63:0]  nn, mm, aa, rr, lm;
    int lb;
    r = d;
    if (w[31:24] == 8'h04 && !w[21] && w[14]) begin
      lb = 1 << w[23:22];
      lm = (lb == 8) ? '1 : ((64'd1 << (lb * 8)) - 64'd1);
      for (int k = 0; k < nbytes; k += lb) begin
        if (p[k]) begin
          nn = 64'(n >> (k * 8)) & lm;
          mm = 64'(m >> (k * 8)) & lm;
          aa = 64'(a >> (k * 8)) & lm;
          rr = (w[13] ? (aa - nn * mm) : (aa + nn * mm)) & lm;
          mask = {192'd0, lm} << (k * 8);
          r = (r & ~mask) | ({192'd0, rr} << (k * 8));
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [255:0] n, input logic [255:0] m,
                       input logic [255:0] a, input logic [255:0] d, input logic [31:0] p);
    @(negedge clk);
    insn = w; vn = n; vm = m; va = a; vd = d; pred = p;
    @(negedge clk);
  endtask

  task automatic check_both(input string tag);
    logic [255:0] e;
    e = model(insn, vn, vm, va, vd, pred, 32);
    chk(tag, "wide result", w_res, e);
    e = model(insn, vn, vm, va, vd, pred, 16);
    chk(tag, "narrow result", {128'd0, s_res}, {128'd0, e[127:0]});
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    apply(mk(2'd0, 3'b010, 5'd1, 3'd1, 5'd2, 5'd3), '1, '1, '1, '1, '1);
    chk("R10", "reset match", {255'd0, w_match}, 256'd0);
    chk("R10", "reset result", w_res, 256'd0);
    chk("R10", "reset rd", {251'd0, w_rd}, 256'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_decode();
    apply(mk(2'd1, 3'b011, 5'd4, 3'd2, 5'd5, 5'd6), '0, '0, '0, '0, '0);
    chk("R1", "match mls", {255'd0, w_match}, 256'd1);
    chk("R1", "narrow match", {255'd0, s_match}, 256'd1);
    apply(mk(2'd1, 3'b110, 5'd4, 3'd2, 5'd5, 5'd6), '0, '0, '0, '0, '0);
    chk("R1", "match mad", {255'd0, w_match}, 256'd1);
    apply(mk(2'd1, 3'b001, 5'd4, 3'd2, 5'd5, 5'd6), '0, '0, '0, '0, '0);
    chk("R1", "opcode 001", {255'd0, w_match}, 256'd0);
    apply(mk(2'd1, 3'b010, 5'd4, 3'd2, 5'd5, 5'd6) | 32'h0020_0000, '0, '0, '0, '0, '0);
    chk("R1", "bit21 set", {255'd0, w_match}, 256'd0);
    apply(mk(2'd1, 3'b010, 5'd4, 3'd2, 5'd5, 5'd6) ^ 32'h0100_0000, '0, '0, '0, '0, '0);
    chk("R1", "bad tag", {255'd0, w_match}, 256'd0);
  endtask

  task automatic t_indices();
    apply(mk(2'd2, 3'b010, 5'd17, 3'd5, 5'd9, 5'd30), '0, '0, '0, '0, '0);
    chk("R7", "indices addend form",
        {229'd0, w_rd, w_ra, w_rn, w_rm, w_pg}, {229'd0, 5'd30, 5'd30, 5'd9, 5'd17, 3'd5});
    chk("R7", "narrow indices",
        {229'd0, s_rd, s_ra, s_rn, s_rm, s_pg}, {229'd0, 5'd30, 5'd30, 5'd9, 5'd17, 3'd5});
    apply(mk(2'd2, 3'b111, 5'd17, 3'd7, 5'd9, 5'd30), '0, '0, '0, '0, '0);
    chk("R8", "indices mcand form",
        {229'd0, w_rd, w_ra, w_rn, w_rm, w_pg}, {229'd0, 5'd30, 5'd9, 5'd30, 5'd17, 3'd7});
  endtask

  task automatic t_nonmatch();
    logic [255:0] d;
    d = rnd256();
    apply(32'h0500_4000, rnd256(), rnd256(), rnd256(), d, '1);
    chk("R9", "result kept", w_res, d);
    chk("R9", "narrow kept", {128'd0, s_res}, {128'd0, d[127:0]});
    chk("R9", "indices zero", {229'd0, w_rd, w_ra, w_rn, w_rm, w_pg}, 256'd0);
  endtask

  task automatic t_sizes();
    for (int s = 0; s < 4; s++) begin
      apply(mk(2'(s), 3'b010, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), '1);
      check_both("R2 R3 mla full");
      apply(mk(2'(s), 3'b111, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), '1);
      check_both("R2 R4 mls full");
    end
  endtask

  task automatic t_wrap();
    apply(mk(2'd3, 3'b010, 5'd1, 3'd0, 5'd2, 5'd3), '1, '1, '1, '0, 32'h0000_0001);
    chk("R3", "64-bit wrap lane0", {192'd0, w_res[63:0]}, 256'd0);
    apply(mk(2'd0, 3'b011, 5'd1, 3'd0, 5'd2, 5'd3), {32{8'd2}}, {32{8'd3}}, '0, '0, '1);
    chk("R4", "byte underflow", w_res, {32{8'hFA}});
  endtask

  task automatic t_predicate();
    logic [255:0] d;
    d = rnd256();
    apply(mk(2'd1, 3'b010, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), d, 32'hAAAA_AAAA);
    chk("R5", "odd bits only, 16-bit lanes", w_res, d);
    apply(mk(2'd2, 3'b010, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), d, 32'hEEEE_EEEE);
    chk("R5", "non-lowest bits, 32-bit lanes", w_res, d);
    apply(mk(2'd1, 3'b110, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), 32'h5555_5555);
    check_both("R5 lowest bits only");
    apply(mk(2'd0, 3'b010, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), 32'h0F0F_3C96);
    check_both("R6 mixed byte lanes");
    apply(mk(2'd3, 3'b011, 5'd1, 3'd0, 5'd2, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), 32'h0001_0100);
    check_both("R6 mixed dword lanes");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      apply(mk(2'($urandom), {$urandom_range(0, 1) == 1, 1'b1, 1'($urandom)},
               5'($urandom), 3'($urandom), 5'($urandom), 5'($urandom)),
            rnd256(), rnd256(), rnd256(), rnd256(), $urandom);
      check_both("R3 R4 R5 R6 random");
    end
  endtask

  initial begin
    t_reset();
    t_decode();
    t_indices();
    t_nonmatch();
    t_sizes();
    t_wrap();
    t_predicate();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule